// File: doc/BRIEF.md
# Indirect Secondary Register Bridge

This block lets a host reach a private bank of 8-bit secondary registers through just two primary registers on its own bus: a pointer register and a data port. The host first writes the pointer register with a secondary register number plus a direction flag, then touches the data port. The data port either stores the byte into the selected secondary register or returns that register's contents, depending on the flag.

Primary registers are spaced on the bus by a configurable stride. The byte offset of a primary register is its index shifted left by `BUS_SHIFT`. The pointer keeps its value after a data access, so repeated data accesses hit the same secondary register.

One secondary register carries a control bit that drives the active-low enable of an attached one-wire master. That master, and any other function behind the bank, lie outside this block.

Top module: `sreg_bridge`

## Requirements
- R1: After reset every secondary register reads 0x00, except register 0x28, which reads 0x80. The pointer register reads 0x00, and `owm_en_n` is 1.
- R2: The pointer register is primary index 5 and the data port is primary index 6. The byte offset of a primary register is its index shifted left by `BUS_SHIFT` (default 2, so the offsets are 0x14 and 0x18).
- R3: A value written to the pointer register is split as follows: bit 7 is the read-mode flag and bits [6:0] are the secondary register number. Reading the pointer register returns the whole byte last written.
- R4: A data-port write with the read-mode flag clear stores the write byte into the selected secondary register on that clock edge.
- R5: A data-port read with the read-mode flag set returns the selected secondary register's value in the same cycle.
- R6: A data-port write with the read-mode flag set changes no secondary register.
- R7: A data-port read with the read-mode flag clear returns 0x00.
- R8: A data access leaves the pointer register unchanged.
- R9: `owm_en_n` always equals bit 7 of secondary register 0x28. A 0 in that bit enables the one-wire master.
- R10: An access to a misaligned offset, to primary indices 0 to 4, or to an index of 7 or above is ignored: it writes nothing and reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Primary bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the primary access |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte; combinational for the current access |
| owm_en_n | output | 1 | Active-low enable of the one-wire master |

## Verification
The hardest case to reach from the ports is a data-port write that arrives while the pointer holds read mode. It must leave the bank untouched, and that can only be seen through a later read. The stimulus therefore fills the whole bank with a known pattern first. It then issues data writes with read mode set, and sweeps the bank back to show that nothing moved. Register 0x28 also gets a write-mode write of each polarity, so `owm_en_n` is seen in both states.

// File: rtl/sreg_bridge_pkg.sv
package sreg_bridge_pkg;

    typedef struct packed {
        logic       rd_mode;
        logic [6:0] sec_num;
    } ptr_t;

    typedef enum logic [1:0] {
        PRI_NONE = 2'd0,
        PRI_PTR  = 2'd1,
        PRI_DATA = 2'd2
    } pri_sel_e;

endpackage

// File: rtl/sreg_pri_decode.sv
module sreg_pri_decode
    import sreg_bridge_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BUS_SHIFT = 2,
    parameter int PTR_IDX   = 5,
    parameter int DATA_IDX  = 6
) (
    input  logic [ADDR_W-1:0] bus_addr,
    output pri_sel_e          pri_sel
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << BUS_SHIFT) - 1);
    localparam logic [ADDR_W-1:0] PTR_IDX_V  = ADDR_W'(PTR_IDX);
    localparam logic [ADDR_W-1:0] DATA_IDX_V = ADDR_W'(DATA_IDX);

    logic [ADDR_W-1:0] idx;
    logic              aligned;

    always_comb begin
        idx     = bus_addr >> BUS_SHIFT;
        aligned = (bus_addr & LOW_MASK) == '0;
        pri_sel = PRI_NONE;
        if (aligned && idx == PTR_IDX_V) begin
            pri_sel = PRI_PTR;
        end else if (aligned && idx == DATA_IDX_V) begin
            pri_sel = PRI_DATA;
        end
    end

    always_comb begin
        AST_DECODE_ALIGNED: assert (pri_sel == PRI_NONE || (bus_addr & LOW_MASK) == '0); // R10
    end

endmodule

// File: rtl/sreg_file.sv
module sreg_file #(
    parameter int          NUM_SEC   = 128,
    parameter int          DATA_W    = 8,
    parameter int          EN_REG    = 'h28,
    parameter logic [7:0]  EN_RESET  = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [6:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [6:0]        rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] en_reg_val
);
    localparam int SEC_MAX = NUM_SEC - 1;

    logic [DATA_W-1:0] bank_q [NUM_SEC];
    logic [DATA_W-1:0] bank_d [NUM_SEC];

    always_comb begin
        for (int i = 0; i < NUM_SEC; i++) begin
            bank_d[i] = bank_q[i];
        end
        if (wr_en && int'(wr_idx) <= SEC_MAX) begin
            bank_d[int'(wr_idx)] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SEC; i++) begin
                bank_q[i] <= (i == EN_REG) ? DATA_W'(EN_RESET) : '0;
            end
        end else begin
            for (int i = 0; i < NUM_SEC; i++) begin
                bank_q[i] <= bank_d[i];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_idx) <= SEC_MAX) begin
            rd_data = bank_q[int'(rd_idx)];
        end
    end

    assign en_reg_val = bank_q[EN_REG];

    AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_reg_val)); // R6

endmodule

// File: rtl/sreg_bridge.sv
module sreg_bridge
    import sreg_bridge_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BUS_SHIFT = 2,
    parameter int NUM_SEC   = 128,
    parameter int EN_REG    = 'h28,
    parameter int EN_BIT    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              owm_en_n
);
    localparam logic [7:0] EN_RESET = 8'(1 << EN_BIT);

    typedef struct packed {
        ptr_t ptr;
    } state_t;

    state_t   st_q, st_d;
    pri_sel_e pri_sel;
    logic     file_wr;
    logic [7:0] file_rd;
    logic [7:0] en_val;

    sreg_pri_decode #(
        .ADDR_W   (ADDR_W),
        .BUS_SHIFT(BUS_SHIFT),
        .PTR_IDX  (5),
        .DATA_IDX (6)
    ) u_decode (
        .bus_addr(bus_addr),
        .pri_sel (pri_sel)
    );

    sreg_file #(
        .NUM_SEC (NUM_SEC),
        .DATA_W  (8),
        .EN_REG  (EN_REG),
        .EN_RESET(EN_RESET)
    ) u_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (file_wr),
        .wr_idx    (st_q.ptr.sec_num),
        .wr_data   (bus_wdata),
        .rd_idx    (st_q.ptr.sec_num),
        .rd_data   (file_rd),
        .en_reg_val(en_val)
    );

    always_comb begin
        st_d      = st_q;
        file_wr   = 1'b0;
        bus_rdata = 8'h00;
        if (bus_sel && bus_we) begin
            if (pri_sel == PRI_PTR) begin
                st_d.ptr = ptr_t'(bus_wdata);
            end else if (pri_sel == PRI_DATA) begin
                file_wr = !st_q.ptr.rd_mode;
            end
        end
        if (bus_sel && !bus_we) begin
            if (pri_sel == PRI_PTR) begin
                bus_rdata = 8'(st_q.ptr);
            end else if (pri_sel == PRI_DATA && st_q.ptr.rd_mode) begin
                bus_rdata = file_rd;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign owm_en_n = en_val[EN_BIT];

    AST_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && pri_sel == PRI_DATA) |=> $stable(st_q)); // R8

    AST_RDMODE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && pri_sel == PRI_DATA && st_q.ptr.rd_mode) |=> $stable(owm_en_n)); // R6

    AST_WRMODE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && pri_sel == PRI_DATA && !st_q.ptr.rd_mode) |-> bus_rdata == 8'h00); // R7

    AST_ENABLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && pri_sel == PRI_DATA && !st_q.ptr.rd_mode
         && int'(st_q.ptr.sec_num) == EN_REG) |=> owm_en_n == $past(bus_wdata[EN_BIT])); // R9

    AST_UNDECODED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && pri_sel == PRI_NONE) |-> bus_rdata == 8'h00); // R10

endmodule

// File: tb/sreg_bridge_bench.sv
module sreg_bridge_bench;
    localparam int ADDR_W = 8;
    localparam logic [7:0] PTR_OFS  = 8'h14;
    localparam logic [7:0] DATA_OFS = 8'h18;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       bus_sel = 0;
    logic       bus_we = 0;
    logic [7:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       owm_en_n;

    int checks = 0;
    int failures = 0;
    logic [7:0] model [128];
    logic [7:0] got;

    always #10 clk = ~clk;

    sreg_bridge u_sreg_bridge (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .owm_en_n(owm_en_n)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    function automatic logic [7:0] pat(int i, int k);
        return 8'((i * 29 + 11 + k * 71) & 8'hff);
    endfunction

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) model[i] = (i == 'h28) ? 8'h80 : 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        check("R1 owm_en_n", {7'b0, owm_en_n}, 8'h01);
        rd(PTR_OFS, got); check("R1 ptr", got, 8'h00);
        for (int i = 0; i < 128; i++) begin
            wr(PTR_OFS, 8'(8'h80 | i));
            rd(DATA_OFS, got); check("R1 R5 reset bank", got, model[i]);
        end

        // R2 R3 R4: fill bank in write mode, read pointer back
        for (int i = 0; i < 128; i++) begin
            wr(PTR_OFS, 8'(i));
            rd(PTR_OFS, got); check("R3 ptr readback", got, 8'(i));
            wr(DATA_OFS, pat(i, 0));
            model[i] = pat(i, 0);
            // R9
            check("R9 owm_en_n", {7'b0, owm_en_n}, {7'b0, model['h28][7]});
            // R7: data read in write mode
            rd(DATA_OFS, got); check("R7 wrmode read", got, 8'h00);
        end
        for (int i = 0; i < 128; i++) begin
            wr(PTR_OFS, 8'(8'h80 | i));
            rd(DATA_OFS, got); check("R4 R5 readback", got, model[i]);
            // R6: write in read mode ignored
            wr(DATA_OFS, ~model[i]);
            rd(DATA_OFS, got); check("R6 rdmode write ignored", got, model[i]);
            // R8: pointer unchanged after data accesses
            rd(PTR_OFS, got); check("R8 ptr held", got, 8'(8'h80 | i));
        end

        // R9: both polarities of the enable bit
        wr(PTR_OFS, 8'h28); wr(DATA_OFS, 8'h7f);
        check("R9 enable active", {7'b0, owm_en_n}, 8'h00);
        wr(DATA_OFS, 8'h80);
        check("R9 enable inactive", {7'b0, owm_en_n}, 8'h01);
        wr(DATA_OFS, 8'h00);
        check("R9 enable active again", {7'b0, owm_en_n}, 8'h00);
        model['h28] = 8'h00;

        // R10: undecoded offsets ignored, read zero
        wr(PTR_OFS, 8'h28);
        for (int a = 0; a < 64; a++) begin
            if (8'(a) != PTR_OFS && 8'(a) != DATA_OFS) begin
                wr(8'(a), 8'h85);
                rd(8'(a), got); check("R10 undecoded read", got, 8'h00);
            end
        end
        rd(PTR_OFS, got); check("R10 ptr untouched", got, 8'h28);
        check("R10 enable untouched", {7'b0, owm_en_n}, 8'h00);
        wr(PTR_OFS, 8'ha8);
        rd(DATA_OFS, got); check("R10 bank untouched", got, model['h28]);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule